// File: doc/BRIEF.md
# YCbCr to RGB Colour-Space Converter

This block turns a stream of 8-bit luma and chroma samples into 8-bit red, green and blue. One Y, Cb, Cr triple is accepted on each cycle in which `in_valid` is high. The matching RGB triple leaves three clock edges later with `out_valid` high. The stream may run back to back or with gaps.

The conversion is set by three 32-bit configuration words, written through a small write port. Each word holds signed 8-bit input offsets or 10-bit signed fixed-point coefficients. The datapath has three register stages:
- The first stage applies the offsets.
- The second stage forms nine products.
- The third stage sums each row, rounds it and clamps the result to 0..255.

The configuration words feed the datapath directly. They must therefore only be rewritten while no samples are in flight, that is, between frames.

Top module: `ycc2rgb_csc`

## Requirements
- R1: A write with `cfg_we` high and `cfg_sel` equal to 0, 1 or 2 stores `cfg_data` into that word at the clock edge. A write with `cfg_sel` equal to 3 changes nothing.
- R2: Each coefficient is 10 bits. Bits 9:8 are an integer code (00 = 0, 01 = +1, 10 = +2, 11 = -1), and bits 7:0 are an unsigned fraction in 1/256 units that is added to that integer.
- R3: Field placement, with bit positions in words 0, 1 and 2:
  - Word 1: luma gain in bits 11:2, Cb-to-green gain in bits 31:22, Cr-to-green gain in bits 21:12.
  - Word 2: Cb-to-red gain in bits 29:20, Cr-to-red gain in bits 19:10, Cb-to-blue gain in bits 9:0.
  - Cr-to-blue gain: its low 8 bits are in word 0 bits 31:24 and its top 2 bits are in word 1 bits 1:0.
- R4: The input offsets are signed 8-bit values in word 0. They are applied as follows:
  - Y' = Y + off_y, with off_y in bits 23:16.
  - Cb' = Cb - 128 + off_cb, with off_cb in bits 15:8.
  - Cr' = Cr - 128 + off_cr, with off_cr in bits 7:0.
- R5: The outputs are computed from the adjusted samples, with one luma gain shared by all three rows:
  - R = Ky·Y' + Kcb_r·Cb' + Kcr_r·Cr'
  - G = Ky·Y' + Kcb_g·Cb' + Kcr_g·Cr'
  - B = Ky·Y' + Kcb_b·Cb' + Kcr_b·Cr'
- R6: Each row sum, held in 1/256 units, is rounded half-up: (sum + 128) shifted right arithmetically by 8.
- R7: Each rounded result is clamped to the range 0..255.
- R8: `out_valid` and the RGB data follow an accepted sample by exactly three clock edges.
- R9: A synchronous active-high `rst` clears the valid pipeline and all three configuration words to zero. With zero words, every output is 0.
- R10: One sample is accepted on every cycle, with no stall between back-to-back samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select (0..2; 3 is ignored) |
| cfg_data | input | 32 | Configuration write data |
| in_valid | input | 1 | Input sample valid |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
The bench aims at several corner cases, each with a distinct symptom if the design gets it wrong:
- **Integer code 11 (−1).** Hand-built words use this code, including on the Cr-to-blue gain whose two halves sit in different words. A decoder that treats 11 as +3, or joins the split field in the wrong order, gives blue and red values far off the expected ones.
- **Rounding.** A gain of 0.5 produces exact half values. Truncating or rounding half-down shows up as an output one below the expected value.
- **Saturation.** Corner samples at Y = 0, 16, 235 and 255 and chroma at 16, 128 and 240 drive the sums below zero and above 255. Missing clamps would wrap these around.
- **Ignored word select and latency.** A write to select 3 is followed by samples checked against the unchanged model. A one-cycle error in the valid delay appears as an `out_valid` mismatch on a lone sample.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    localparam int CFG_W   = 32;
    localparam int CODE_W  = 10;
    localparam int FRAC_W  = 8;
    localparam int OFS_W   = 8;
    localparam int CVAL_W  = FRAC_W + 4;

    typedef logic signed [CVAL_W-1:0] coef_t;
    typedef logic signed [OFS_W-1:0]  ofs_t;

    typedef struct packed {
        coef_t luma;
        coef_t cb_r;
        coef_t cr_r;
        coef_t cb_g;
        coef_t cr_g;
        coef_t cb_b;
        coef_t cr_b;
    } coef_set_t;

    typedef struct packed {
        ofs_t y;
        ofs_t cb;
        ofs_t cr;
    } ofs_set_t;

    // Integer code sits above the fraction; result is in 1/256 units.
    function automatic coef_t decode_coef(input logic [CODE_W-1:0] code);
        logic signed [CVAL_W-FRAC_W-1:0] whole;
        unique case (code[CODE_W-1 -: 2])
            2'b00:   whole = 0;
            2'b01:   whole = 1;
            2'b10:   whole = 2;
            default: whole = -1;
        endcase
        return coef_t'({whole, code[FRAC_W-1:0]});
    endfunction

endpackage

// File: rtl/ycc_cfg_bank.sv
module ycc_cfg_bank
    import ycc_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int N_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] sel,
    input  logic [CFG_W-1:0]  data,
    output coef_set_t         coefs,
    output ofs_set_t          ofs
);

    logic [CFG_W-1:0] words [N_WORDS];

    generate
        for (genvar w = 0; w < N_WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)
                    words[w] <= '0;
                else if (we && sel == ADDR_W'(w))
                    words[w] <= data;
            end

            // R1: a select of an existing word stores the data
            assert_cfg_store_R1: assert property (@(posedge clk) disable iff (rst)
                (we && sel == ADDR_W'(w)) |=> (words[w] == $past(data)));

            // R1: an out-of-range select leaves the word alone
            assert_cfg_ignore_R1: assert property (@(posedge clk) disable iff (rst)
                (we && sel >= ADDR_W'(N_WORDS)) |=> $stable(words[w]));
        end
    endgenerate

    // Field unpacking (layout fixed by R3)
    always_comb begin
        ofs.y      = ofs_t'(words[0][23:16]);
        ofs.cb     = ofs_t'(words[0][15:8]);
        ofs.cr     = ofs_t'(words[0][7:0]);
        coefs.cr_b = decode_coef({words[1][1:0], words[0][31:24]});
        coefs.luma = decode_coef(words[1][11:2]);
        coefs.cr_g = decode_coef(words[1][21:12]);
        coefs.cb_g = decode_coef(words[1][31:22]);
        coefs.cb_b = decode_coef(words[2][9:0]);
        coefs.cr_r = decode_coef(words[2][19:10]);
        coefs.cb_r = decode_coef(words[2][29:20]);
    end

    logic [1:0] unused_w2_top;
    assign unused_w2_top = words[2][31:30];

    // R2: integer code 11 is the only one that yields a negative gain
    assert_coef_sign_R2: assert property (@(posedge clk) disable iff (rst)
        (coefs.luma < 0) == (words[1][11:10] == 2'b11));

endmodule

// File: rtl/ycc_offset_stage.sv
module ycc_offset_stage
    import ycc_pkg::*;
#(
    parameter int PIX_W = 8,
    localparam int ADJ_W = PIX_W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    valid_i,
    input  logic [PIX_W-1:0]        y_i,
    input  logic [PIX_W-1:0]        cb_i,
    input  logic [PIX_W-1:0]        cr_i,
    input  ofs_set_t                ofs,
    output logic                    valid_q,
    output logic signed [ADJ_W-1:0] y_q,
    output logic signed [ADJ_W-1:0] cb_q,
    output logic signed [ADJ_W-1:0] cr_q
);

    localparam int CENTER = 1 << (PIX_W - 1);

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else
            valid_q <= valid_i;
    end

    always_ff @(posedge clk) begin
        y_q  <= ADJ_W'(signed'({1'b0, y_i}))  + ADJ_W'(ofs.y);
        cb_q <= ADJ_W'(signed'({1'b0, cb_i})) - ADJ_W'(CENTER) + ADJ_W'(ofs.cb);
        cr_q <= ADJ_W'(signed'({1'b0, cr_i})) - ADJ_W'(CENTER) + ADJ_W'(ofs.cr);
    end

    // R4: mid-scale chroma with no offset lands on zero
    assert_chroma_center_R4: assert property (@(posedge clk) disable iff (rst)
        (ofs.cb == 0 && cb_i == PIX_W'(CENTER)) |=> (cb_q == 0));

endmodule

// File: rtl/ycc_mac_channel.sv
module ycc_mac_channel
    import ycc_pkg::*;
#(
    parameter int PIX_W = 8,
    localparam int ADJ_W  = PIX_W + 2,
    localparam int PROD_W = CVAL_W + ADJ_W,
    localparam int ACC_W  = PROD_W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  coef_t                   k_y,
    input  coef_t                   k_cb,
    input  coef_t                   k_cr,
    input  logic signed [ADJ_W-1:0] y_adj,
    input  logic signed [ADJ_W-1:0] cb_adj,
    input  logic signed [ADJ_W-1:0] cr_adj,
    output logic [PIX_W-1:0]        pix
);

    localparam int HALF    = 1 << (FRAC_W - 1);
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    logic signed [PROD_W-1:0] p_y, p_cb, p_cr;
    logic signed [ACC_W-1:0]  rounded;

    // stage 2: products
    always_ff @(posedge clk) begin
        p_y  <= k_y  * y_adj;
        p_cb <= k_cb * cb_adj;
        p_cr <= k_cr * cr_adj;
    end

    // stage 3: sum, round half-up, clamp
    always_comb begin
        rounded = (ACC_W'(p_y) + ACC_W'(p_cb) + ACC_W'(p_cr) + ACC_W'(HALF)) >>> FRAC_W;
    end

    always_ff @(posedge clk) begin
        if (rounded < 0)
            pix <= '0;
        else if (rounded > ACC_W'(PIX_MAX))
            pix <= PIX_W'(PIX_MAX);
        else
            pix <= rounded[PIX_W-1:0];
    end

    assert_sat_low_R7: assert property (@(posedge clk) disable iff (rst)
        (rounded < 0) |=> (pix == '0));

    assert_sat_high_R7: assert property (@(posedge clk) disable iff (rst)
        (rounded > ACC_W'(PIX_MAX)) |=> (pix == PIX_W'(PIX_MAX)));

endmodule

// File: rtl/ycc2rgb_csc.sv
module ycc2rgb_csc
    import ycc_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_y,
    input  logic [PIX_W-1:0]  in_cb,
    input  logic [PIX_W-1:0]  in_cr,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);

    localparam int ADJ_W = PIX_W + 2;
    localparam int N_CH  = 3;

    coef_set_t coefs;
    ofs_set_t  ofs;

    ycc_cfg_bank #(.ADDR_W(ADDR_W), .N_WORDS(3)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .data  (cfg_data),
        .coefs (coefs),
        .ofs   (ofs)
    );

    logic                    v_s1, v_s2;
    logic signed [ADJ_W-1:0] y_a, cb_a, cr_a;

    ycc_offset_stage #(.PIX_W(PIX_W)) u_ofs (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .y_i     (in_y),
        .cb_i    (in_cb),
        .cr_i    (in_cr),
        .ofs     (ofs),
        .valid_q (v_s1),
        .y_q     (y_a),
        .cb_q    (cb_a),
        .cr_q    (cr_a)
    );

    coef_t            k_cb [N_CH];
    coef_t            k_cr [N_CH];
    logic [PIX_W-1:0] pix  [N_CH];

    assign k_cb[0] = coefs.cb_r;
    assign k_cr[0] = coefs.cr_r;
    assign k_cb[1] = coefs.cb_g;
    assign k_cr[1] = coefs.cr_g;
    assign k_cb[2] = coefs.cb_b;
    assign k_cr[2] = coefs.cr_b;

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            ycc_mac_channel #(.PIX_W(PIX_W)) u_mac (
                .clk    (clk),
                .rst    (rst),
                .k_y    (coefs.luma),
                .k_cb   (k_cb[ch]),
                .k_cr   (k_cr[ch]),
                .y_adj  (y_a),
                .cb_adj (cb_a),
                .cr_adj (cr_a),
                .pix    (pix[ch])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            v_s2      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v_s2      <= v_s1;
            out_valid <= v_s2;
        end
    end

    assign out_r = pix[0];
    assign out_g = pix[1];
    assign out_b = pix[2];

    // edges seen since reset, saturating at the pipeline depth
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_reset_idle_R9: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/test_ycc2rgb_csc.sv
`timescale 1ns/1ps
module test_ycc2rgb_csc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_y = '0, in_cb = '0, in_cr = '0;
    logic        out_valid;
    logic [7:0]  out_r, out_g, out_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] mw [3];

    // expected pipeline: index 0 newest
    bit    pv [3];
    int    pr [3], pg [3], pb [3];
    string ptag [3];

    always #4 clk = ~clk;

    ycc2rgb_csc i_ycc2rgb_csc (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic int dec(input logic [9:0] c);
        int w;
        case (c[9:8])
            2'b00: w = 0;
            2'b01: w = 1;
            2'b10: w = 2;
            default: w = -1;
        endcase
        return w * 256 + int'(c[7:0]);
    endfunction

    function automatic int clamp_round(input int a);
        int r;
        r = (a + 128) >>> 8;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic model(input int y, input int cb, input int cr,
                         output int r, output int g, output int b);
        int ky, kcbr, kcrr, kcbg, kcrg, kcbb, kcrb, ya, cba, cra;
        ky   = dec(mw[1][11:2]);
        kcbg = dec(mw[1][31:22]);
        kcrg = dec(mw[1][21:12]);
        kcbr = dec(mw[2][29:20]);
        kcrr = dec(mw[2][19:10]);
        kcbb = dec(mw[2][9:0]);
        kcrb = dec({mw[1][1:0], mw[0][31:24]});
        ya  = y + int'($signed(mw[0][23:16]));
        cba = cb - 128 + int'($signed(mw[0][15:8]));
        cra = cr - 128 + int'($signed(mw[0][7:0]));
        r = clamp_round(ky*ya + kcbr*cba + kcrr*cra);
        g = clamp_round(ky*ya + kcbg*cba + kcrg*cra);
        b = clamp_round(ky*ya + kcbb*cba + kcrb*cra);
    endtask

    // one cycle: check the sample driven three steps earlier, then drive a new one
    task automatic step(input bit v, input int y, input int cb, input int cr,
                        input int er, input int eg, input int eb, input string tag);
        @(negedge clk);
        n_tests++;
        if (out_valid !== pv[2]) begin
            n_fail++;
            $display("FAIL R8 out_valid actual %0b expected %0b", out_valid, pv[2]);
        end else if (pv[2]) begin
            if (out_r !== pr[2][7:0] || out_g !== pg[2][7:0] || out_b !== pb[2][7:0]) begin
                n_fail++;
                $display("FAIL %s rgb actual %0d,%0d,%0d expected %0d,%0d,%0d",
                         ptag[2], out_r, out_g, out_b, pr[2], pg[2], pb[2]);
            end
        end
        for (int i = 2; i > 0; i--) begin
            pv[i] = pv[i-1]; pr[i] = pr[i-1]; pg[i] = pg[i-1]; pb[i] = pb[i-1];
            ptag[i] = ptag[i-1];
        end
        pv[0] = v; pr[0] = er; pg[0] = eg; pb[0] = eb; ptag[0] = tag;
        in_valid = v; in_y = y[7:0]; in_cb = cb[7:0]; in_cr = cr[7:0];
    endtask

    task automatic stepm(input bit v, input int y, input int cb, input int cr, input string tag);
        int r, g, b;
        model(y, cb, cr, r, g, b);
        step(v, y, cb, cr, r, g, b, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 0, 0, 0, "R8");
    endtask

    // only between frames: drain first
    task automatic write_word(input int sel, input logic [31:0] d);
        idle(3);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 3) mw[sel] = d;
    endtask

    task automatic load(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        write_word(0, w0);
        write_word(1, w1);
        write_word(2, w2);
    endtask

    task automatic random_run(input int n, input int busy_pct, input string tag);
        for (int i = 0; i < n; i++)
            stepm(($urandom % 100) < busy_pct, $urandom % 256, $urandom % 256, $urandom % 256, tag);
        idle(3);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin
            mw[i] = '0; pv[i] = 1'b0; pr[i] = 0; pg[i] = 0; pb[i] = 0; ptag[i] = "R8";
        end
        repeat (4) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 out_valid during reset actual %0b expected 0", out_valid);
        end
        rst = 1'b0;

        // R9: words cleared by reset give all-zero outputs
        step(1'b1, 200, 30, 220, 0, 0, 0, "R9");
        idle(3);

        // R5: limited-range standard-definition matrix, random traffic
        load(32'h00F00000, 32'hE73304A8, 32'h00066204);
        random_run(300, 75, "R5");
        // R10: unbroken burst
        random_run(120, 100, "R10");

        // R7: corner samples, model and literal expectations
        foreach (mw[k]) ;
        for (int yi = 0; yi < 4; yi++)
            for (int ci = 0; ci < 3; ci++)
                for (int ri = 0; ri < 3; ri++) begin
                    int yv, cv, rv;
                    yv = (yi == 0) ? 0 : (yi == 1) ? 16 : (yi == 2) ? 235 : 255;
                    cv = (ci == 0) ? 16 : (ci == 1) ? 128 : 240;
                    rv = (ri == 0) ? 16 : (ri == 1) ? 128 : 240;
                    stepm(1'b1, yv, cv, rv, "R7");
                end
        step(1'b1, 0,   128, 128, 0,   0,   0,   "R7");
        step(1'b1, 16,  128, 128, 0,   0,   0,   "R7");
        step(1'b1, 235, 128, 128, 255, 255, 255, "R7");
        step(1'b1, 255, 128, 128, 255, 255, 255, "R7");
        idle(3);

        // R8: lone sample, valid exactly three edges later
        stepm(1'b1, 120, 90, 170, "R8");
        idle(4);

        // R3: high-definition matrix words
        load(32'h00F00000, 32'hF2B784A8, 32'h00072A1C);
        random_run(120, 80, "R3");

        // R4: full-range words (zero luma offset)
        load(32'h00000000, 32'hEA34A400, 32'h000599C5);
        random_run(120, 80, "R4");

        // R4: literal offsets +5 / +10 / +20, unity gains on selected paths
        load(32'h00050A14, 32'h00100400, 32'h10000000);
        step(1'b1, 50, 100, 130, 37, 77, 55, "R4");
        idle(3);

        // R2: code 10 = +2 on luma
        load(32'h00000000, 32'h00000800, 32'h00000000);
        step(1'b1, 100, 7, 250, 200, 200, 200, "R2");
        idle(3);
        // R2: code 11 = -1 on Cb-to-red and on the split Cr-to-blue field
        load(32'h00000000, 32'h00000403, 32'h3C000000);
        step(1'b1, 100, 168, 148, 90, 100, 80, "R2");
        idle(3);

        // R6: gain 0.5 gives exact halves
        load(32'h00000000, 32'h00000200, 32'h00000000);
        step(1'b1, 1, 128, 128, 1, 1, 1, "R6");
        step(1'b1, 2, 128, 128, 1, 1, 1, "R6");
        step(1'b1, 3, 128, 128, 2, 2, 2, "R6");
        idle(3);

        // R1: select 3 must not disturb the standard-definition words
        load(32'h00F00000, 32'hE73304A8, 32'h00066204);
        write_word(3, 32'hFFFFFFFF);
        random_run(40, 100, "R1");
        step(1'b1, 235, 240, 16, 0, 0, 0, "R1");
        begin
            int r, g, b;
            model(235, 240, 16, r, g, b);
            pr[0] = r; pg[0] = g; pb[0] = b;
        end
        idle(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule